// File: doc/BRIEF.md
# Multi-Channel Time-Stamp Push Formatter

This block takes time stamps from sixteen hit channels and streams them onto a single 16-bit output bus. No request comes from downstream: a word is driven as soon as one is ready. Each channel offers a 53-bit time value with a one-cycle hit strobe. The value goes into a four-entry queue for that channel. A round-robin arbiter picks a channel with pending data and sends its oldest time value as one to four words. Each word carries the channel number and first-word and last-word markers.

A two-bit range setting chooses how many words make up a hit, and so how many time bits reach the output: 15, 31, 47 or 53. The output side runs on a readout slot that comes every second clock cycle, which models a readout clock at half the input rate. If a channel's queue fills, a sticky per-channel flag is set, and slow control can clear it with a write.

Top module: `tstamp_push_fmt`

## Requirements
- R1: After reset, outValid is low, every fullFlags bit is 0, and the range setting selects 2 words per hit, so the block runs with no configuration.
- R2: A write with modeWrEn high stores modeWrData as the range setting. The encoding is 0 = 1 word, 1 = 2 words, 2 = 3 words, 3 = 4 words. Each hit is sent as exactly that many words.
- R3: Word 0 is {1'b1, time[14:0]}. Word k (k = 1..3) is bits [16k+14 : 16k-1] of the time value with zeros above bit 52. Word 3 is therefore {10'b0, time[52:47]}.
- R4: outChan carries the channel number of the hit. outFirst is high only on word 0. outLast is high only on the final word of the hit.
- R5: outValid is high for a single cycle and never for two cycles in a row. The words of one hit come out on consecutive readout slots, exactly 2 cycles apart, with no other channel's word between them.
- R6: Push operation: a hit that reaches an idle, empty block shows up on the output within 5 cycles, with no input from downstream.
- R7: Round-robin service: when several channels have data, the grant moves on from the channel served last to the next channel in increasing order, with wrap-around. When all channels are loaded, the channels are served in a rotating order and channel 0 gets no precedence.
- R8: Each channel keeps at most 4 pending hits and sends them in arrival order. A hit that arrives while that channel already holds 4 hits, with no removal in the same cycle, is lost.
- R9: When a channel's queue reaches 4 entries, fullFlags for that channel goes to 1. It stays at 1 until a cycle with the matching flagClr bit high. A fill in the same cycle as the clear wins.
- R10: A hit and a removal on the same channel in the same cycle lose no data and leave the count correct.
- R11: A change of the range setting while a hit is being sent does not change that hit's word count. The change applies from the next hit onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Front-end clock |
| rstN | input | 1 | Active-low synchronous reset |
| hitStrobe | input | 16 | One-cycle hit pulse per channel |
| hitTime | input | 848 | Time value per channel, channel n at bits [53n+52:53n] |
| modeWrEn | input | 1 | Write strobe for the range setting |
| modeWrData | input | 2 | New range setting (R2 encoding) |
| flagClr | input | 16 | Clear strobe for each sticky full flag |
| fullFlags | output | 16 | Sticky per-channel queue-full flags |
| outValid | output | 1 | Output word valid, one cycle |
| outData | output | 16 | Output data word |
| outChan | output | 4 | Channel of the current word |
| outFirst | output | 1 | First word of a hit |
| outLast | output | 1 | Final word of a hit |

## Verification
A single hit at each of the four range settings, on channels 0, 5, 2 and 15, checks the word count, slicing, markers and slot spacing. These are the cases where an off-by-one in the slice offsets or in the last-word detection would show up. Loading all sixteen channels twice in back-to-back cycles shows whether the arbiter rotates or falls back toward channel 0, and whether each queue keeps arrival order. A burst of seven hits on one channel at the 4-word setting overfills a queue, which tests the drop and the sticky flag. Hits spaced one readout slot apart, started at both clock phases, force arrival and removal into the same cycle. A range write during a 4-word hit tells apart a setting that is latched at hit start from one that is read on every word.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int NumChan  = 16;
  localparam int ChanW    = $clog2(NumChan);
  localparam int MaxWords = 4;
  localparam int IdxW     = $clog2(MaxWords);
  localparam int WordW    = 16;

  typedef struct packed {
    logic             emit;
    logic [ChanW-1:0] chan;
    logic [IdxW-1:0]  idx;
    logic             first;
    logic             last;
  } rdCtrl_t;
endpackage

// File: rtl/tsf_chan_fifo.sv
module tsf_chan_fifo #(
  parameter int DataW = 53,
  parameter int Depth = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [DataW-1:0] din,
  input  logic             clrFlag,
  output logic [DataW-1:0] dout,
  output logic             notEmpty,
  output logic             fullFlag
);
  localparam int AddrW = (Depth > 1) ? $clog2(Depth) : 1;
  localparam int CntW  = $clog2(Depth + 1);

  logic [DataW-1:0] mem [Depth];
  logic [AddrW-1:0] wrPtr, rdPtr;
  logic [CntW-1:0]  cnt;
  logic             doPush, doPop, fillNow;

  assign doPop   = pop && (cnt != '0);
  assign doPush  = push && ((cnt != CntW'(Depth)) || doPop);
  assign fillNow = doPush && !doPop && (cnt == CntW'(Depth - 1));
  assign dout     = mem[rdPtr];
  assign notEmpty = (cnt != '0);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      cnt      <= '0;
      fullFlag <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AddrW'(Depth - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AddrW'(Depth - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (fillNow)      fullFlag <= 1'b1;
      else if (clrFlag) fullFlag <= 1'b0;
    end
  end

  // R8: a hit into a full queue with no removal leaves it untouched
  p_drop_when_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CntW'(Depth) && push && !pop) |=> (cnt == CntW'(Depth) && $stable(wrPtr)));
  // R10: simultaneous hit and removal keeps the count
  p_pushpop_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop && cnt != '0) |=> $stable(cnt));
  // R9: the flag is sticky until cleared
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && !clrFlag) |=> fullFlag);
endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumChan-1:0] nonEmpty,
  input  logic               modeWrEn,
  input  logic [IdxW-1:0]    modeWrData,
  output rdCtrl_t            ctrl
);
  logic             rdEn, busy, found;
  logic [ChanW-1:0] curChan, lastGrant, gnt;
  logic [IdxW-1:0]  wordIdx, activeLast, modeReg, lastIdx;

  always_comb begin
    found = 1'b0;
    gnt   = lastGrant;
    for (int i = 1; i <= NumChan; i++) begin
      int c;
      c = (int'(lastGrant) + i) % NumChan;
      if (!found && nonEmpty[c]) begin
        found = 1'b1;
        gnt   = ChanW'(c);
      end
    end
  end

  always_comb begin
    lastIdx    = busy ? activeLast : modeReg;
    ctrl.chan  = busy ? curChan : gnt;
    ctrl.idx   = busy ? wordIdx : '0;
    ctrl.first = !busy;
    ctrl.last  = (ctrl.idx == lastIdx);
    ctrl.emit  = rdEn && (busy || found);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdEn       <= 1'b0;
      busy       <= 1'b0;
      curChan    <= '0;
      lastGrant  <= ChanW'(NumChan - 1);
      wordIdx    <= '0;
      activeLast <= IdxW'(1);
      modeReg    <= IdxW'(1);
    end else begin
      rdEn <= !rdEn;
      if (modeWrEn) modeReg <= modeWrData;
      if (ctrl.emit) begin
        if (!busy) begin
          curChan    <= gnt;
          lastGrant  <= gnt;
          activeLast <= modeReg;
        end
        busy    <= !ctrl.last;
        wordIdx <= ctrl.idx + 1'b1;
      end
    end
  end

  // R2: the final word ends the hit
  p_last_ends_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.emit && ctrl.last) |=> !busy);
  // R11: the word count of a hit in progress does not move
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(ctrl.emit && ctrl.last)) |=> $stable(activeLast));
  // R5: no other channel is granted while a hit is being sent
  p_chan_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(ctrl.emit && ctrl.last)) |=> (busy && $stable(curChan)));
endmodule

// File: rtl/tsf_datapath.sv
module tsf_datapath
  import tsf_pkg::*;
#(
  parameter int TimeW = 53,
  parameter int Depth = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NumChan-1:0]       hitStrobe,
  input  logic [NumChan*TimeW-1:0] hitTime,
  input  logic [NumChan-1:0]       flagClr,
  input  rdCtrl_t                  ctrl,
  output logic [NumChan-1:0]       nonEmpty,
  output logic [NumChan-1:0]       fullFlags,
  output logic                     outValid,
  output logic [WordW-1:0]         outData,
  output logic [ChanW-1:0]         outChan,
  output logic                     outFirst,
  output logic                     outLast
);
  localparam int PadW = WordW * MaxWords - 1;

  logic [TimeW-1:0] head [NumChan];
  logic [PadW-1:0]  sel;
  logic [WordW-1:0] word;

  for (genvar g = 0; g < NumChan; g++) begin : g_chan
    tsf_chan_fifo #(.DataW(TimeW), .Depth(Depth)) u_fifo (
      .clk     (clk),
      .rstN    (rstN),
      .push    (hitStrobe[g]),
      .pop     (ctrl.emit && ctrl.last && (ctrl.chan == ChanW'(g))),
      .din     (hitTime[g*TimeW +: TimeW]),
      .clrFlag (flagClr[g]),
      .dout    (head[g]),
      .notEmpty(nonEmpty[g]),
      .fullFlag(fullFlags[g])
    );
  end

  always_comb begin
    sel  = PadW'(head[ctrl.chan]);
    word = {1'b1, sel[WordW-2:0]};
    for (int k = 1; k < MaxWords; k++) begin
      if (ctrl.idx == IdxW'(k)) word = sel[WordW*k-1 +: WordW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outChan  <= '0;
      outFirst <= 1'b0;
      outLast  <= 1'b0;
    end else begin
      outValid <= ctrl.emit;
      if (ctrl.emit) begin
        outData  <= word;
        outChan  <= ctrl.chan;
        outFirst <= ctrl.first;
        outLast  <= ctrl.last;
      end
    end
  end

  // R5: a valid word is never followed by another in the next cycle
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  // R3: the first word carries the marker bit
  p_first_marker_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFirst) |-> outData[WordW-1]);
endmodule

// File: rtl/tstamp_push_fmt.sv
module tstamp_push_fmt
  import tsf_pkg::*;
#(
  parameter int TimeW     = 53,
  parameter int FifoDepth = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NumChan-1:0]       hitStrobe,
  input  logic [NumChan*TimeW-1:0] hitTime,
  input  logic                     modeWrEn,
  input  logic [IdxW-1:0]          modeWrData,
  input  logic [NumChan-1:0]       flagClr,
  output logic [NumChan-1:0]       fullFlags,
  output logic                     outValid,
  output logic [WordW-1:0]         outData,
  output logic [ChanW-1:0]         outChan,
  output logic                     outFirst,
  output logic                     outLast
);
  rdCtrl_t            ctrl;
  logic [NumChan-1:0] nonEmpty;

  tsf_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .nonEmpty  (nonEmpty),
    .modeWrEn  (modeWrEn),
    .modeWrData(modeWrData),
    .ctrl      (ctrl)
  );

  tsf_datapath #(.TimeW(TimeW), .Depth(FifoDepth)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .hitStrobe(hitStrobe),
    .hitTime  (hitTime),
    .flagClr  (flagClr),
    .ctrl     (ctrl),
    .nonEmpty (nonEmpty),
    .fullFlags(fullFlags),
    .outValid (outValid),
    .outData  (outData),
    .outChan  (outChan),
    .outFirst (outFirst),
    .outLast  (outLast)
  );
endmodule

// File: tb/tstamp_push_fmt_bench.sv
module tstamp_push_fmt_bench;
  localparam int ClkPeriod = 10;
  localparam int NCh = 16;
  localparam int TW  = 53;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NCh-1:0]    hitStrobe = '0;
  logic [NCh*TW-1:0] hitTime = '0;
  logic              modeWrEn = 1'b0;
  logic [1:0]        modeWrData = '0;
  logic [NCh-1:0]    flagClr = '0;
  logic [NCh-1:0]    fullFlags;
  logic              outValid;
  logic [15:0]       outData;
  logic [3:0]        outChan;
  logic              outFirst, outLast;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nW = 0;
  logic [15:0] wD [1024];
  logic [3:0]  wC [1024];
  logic        wF [1024];
  logic        wL [1024];
  int          wT [1024];

  always #(ClkPeriod/2) clk = ~clk;

  tstamp_push_fmt u_tstamp_push_fmt (
    .clk(clk), .rstN(rstN), .hitStrobe(hitStrobe), .hitTime(hitTime),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData), .flagClr(flagClr),
    .fullFlags(fullFlags), .outValid(outValid), .outData(outData),
    .outChan(outChan), .outFirst(outFirst), .outLast(outLast)
  );

  always @(negedge clk) begin
    cyc++;
    if (outValid && nW < 1024) begin
      wD[nW] = outData; wC[nW] = outChan; wF[nW] = outFirst;
      wL[nW] = outLast; wT[nW] = cyc; nW++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [52:0] mkTime(input int s);
    logic [31:0] sv;
    sv = s;
    return {sv[20:0], 32'hC3A5_96E1 ^ sv};
  endfunction

  function automatic logic [15:0] expWord(input logic [52:0] t, input int k);
    logic [62:0] p;
    p = {10'b0, t};
    if (k == 0) return {1'b1, t[14:0]};
    return p[16*k-1 +: 16];
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk); modeWrEn = 1'b1; modeWrData = m;
    @(negedge clk); modeWrEn = 1'b0;
  endtask

  task automatic hit(input int ch, input logic [52:0] t);
    @(negedge clk);
    hitStrobe = '0; hitStrobe[ch] = 1'b1; hitTime[ch*TW +: TW] = t;
    @(negedge clk); hitStrobe = '0;
  endtask

  task automatic t_reset();
    settle(3);
    chk(outValid == 1'b0, "R1 valid after reset", outValid, 0);
    chk(fullFlags == '0, "R1 flags after reset", fullFlags, 0);
  endtask

  // R2 R3 R4 R5 R6: one hit, full word sequence checked
  task automatic t_single(input int ch, input int nWords, input int seed);
    int base, c0, bad;
    logic [52:0] t;
    t = mkTime(seed);
    base = nW;
    @(negedge clk);
    c0 = cyc;
    hitStrobe = '0; hitStrobe[ch] = 1'b1; hitTime[ch*TW +: TW] = t;
    @(negedge clk); hitStrobe = '0;
    settle(30);
    chk(nW - base == nWords, "R2 word count", nW - base, nWords);
    if (nW - base == nWords) begin
      chk(wT[base] - c0 <= 5, "R6 push latency", wT[base] - c0, 5);
      bad = 0;
      for (int k = 0; k < nWords; k++) begin
        if (wD[base+k] !== expWord(t, k)) begin
          bad++;
          chk(0, "R3 word data", wD[base+k], expWord(t, k));
        end
        if (wC[base+k] != ch[3:0] || wF[base+k] != (k == 0) || wL[base+k] != (k == nWords-1)) begin
          bad++;
          chk(0, "R4 chan/first/last", {wC[base+k], wF[base+k], wL[base+k]}, {ch[3:0], k == 0, k == nWords-1});
        end
        if (k > 0 && wT[base+k] - wT[base+k-1] != 2) begin
          bad++;
          chk(0, "R5 word spacing", wT[base+k] - wT[base+k-1], 2);
        end
      end
      chk(bad == 0, "R3 R4 R5 hit layout", bad, 0);
    end
  endtask

  task automatic t_fair();
    int base, c0, badOrd, badDat;
    setMode(2'd0);
    base = nW;
    @(negedge clk);
    hitStrobe = '1;
    for (int c = 0; c < NCh; c++) hitTime[c*TW +: TW] = mkTime(c*2);
    @(negedge clk);
    for (int c = 0; c < NCh; c++) hitTime[c*TW +: TW] = mkTime(c*2 + 1);
    @(negedge clk); hitStrobe = '0;
    settle(100);
    chk(nW - base == 32, "R7 words for 32 hits", nW - base, 32);
    if (nW - base == 32) begin
      c0 = wC[base];
      badOrd = 0; badDat = 0;
      for (int k = 0; k < 32; k++) begin
        int ch;
        ch = (c0 + k) % NCh;
        if (wC[base+k] != ch[3:0]) badOrd++;
        if (wD[base+k] !== expWord(mkTime(int'(wC[base+k])*2 + k/16), 0)) badDat++;
      end
      chk(badOrd == 0, "R7 round-robin rotation", badOrd, 0);
      chk(badDat == 0, "R8 per-channel arrival order", badDat, 0);
    end
  endtask

  task automatic t_overflow();
    int base, bad;
    setMode(2'd3);
    base = nW;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      hitStrobe = '0; hitStrobe[9] = 1'b1; hitTime[9*TW +: TW] = mkTime(100 + i);
    end
    @(negedge clk); hitStrobe = '0;
    settle(80);
    chk(nW - base == 16, "R8 only 4 hits kept", nW - base, 16);
    bad = 0;
    if (nW - base == 16)
      for (int k = 0; k < 16; k++)
        if (wD[base+k] !== expWord(mkTime(100 + k/4), k % 4)) bad++;
    chk(bad == 0, "R8 kept hits are the oldest", bad, 0);
    chk(fullFlags == 16'h0200, "R9 flag set for channel 9", fullFlags, 16'h0200);
    settle(20);
    chk(fullFlags == 16'h0200, "R9 flag sticky after drain", fullFlags, 16'h0200);
    @(negedge clk); flagClr = 16'h0200;
    @(negedge clk); flagClr = '0;
    settle(2);
    chk(fullFlags == '0, "R9 flag cleared", fullFlags, 0);
  endtask

  task automatic t_midchange();
    int base;
    setMode(2'd3);
    base = nW;
    hit(1, mkTime(300));
    settle(2);
    @(negedge clk); modeWrEn = 1'b1; modeWrData = 2'd0;
    @(negedge clk); modeWrEn = 1'b0;
    settle(20);
    hit(1, mkTime(301));
    settle(20);
    chk(nW - base == 5, "R11 4 words then 1 word", nW - base, 5);
    if (nW - base == 5) begin
      chk(wL[base+3] && !wL[base+2], "R11 hit in flight keeps 4 words", {wL[base+2], wL[base+3]}, 2'b01);
      chk(wF[base+4] && wL[base+4] && wD[base+4] === expWord(mkTime(301), 0),
          "R11 next hit uses new setting", wD[base+4], expWord(mkTime(301), 0));
    end
  endtask

  task automatic t_pushpop(input int offset);
    int base, bad;
    setMode(2'd0);
    settle(offset);
    base = nW;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      hitStrobe = '0; hitStrobe[4] = 1'b1; hitTime[4*TW +: TW] = mkTime(500 + i);
      @(negedge clk); hitStrobe = '0;
    end
    settle(20);
    chk(nW - base == 20, "R10 no hit lost", nW - base, 20);
    bad = 0;
    if (nW - base == 20)
      for (int k = 0; k < 20; k++)
        if (wD[base+k] !== expWord(mkTime(500 + k), 0) || wC[base+k] != 4'd4) bad++;
    chk(bad == 0, "R10 data intact in order", bad, 0);
    chk(fullFlags == '0, "R10 no full flag", fullFlags, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    settle(4);
    rstN = 1'b1;
    t_reset();
    t_single(5, 2, 11);        // R1 default setting
    setMode(2'd3); t_single(2, 4, 22);
    setMode(2'd0); t_single(0, 1, 33);
    setMode(2'd2); t_single(15, 3, 44);
    setMode(2'd1); t_single(7, 2, 55);
    t_fair();
    t_overflow();
    t_midchange();
    t_pushpop(0);
    t_pushpop(1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule